// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface unit of a 16-bit processor whose address and data share one set of pins. A caller presents a single transfer: an address, memory or I/O space, read or write, byte or word size, and write data. While idle, the block takes the transfer in on one clock edge. It then runs a bus cycle of four T states. T1 puts the address on the shared lines and pulses the address latch strobe. T2 asserts the read or write strobe, and on a write the data takes the place of the address. T3 lets the slave respond. T4 drops the strobes. The slave stretches the cycle by holding `ready_i` low, which adds wait states between T3 and T4.

The byte lanes are coded by an active-low high-byte enable together with address bit 0. A word access at an odd address does not fit in one lane pair, so the block runs it as two byte cycles. The low byte goes first, at the odd address on the upper lane. The high byte follows at the next address on the lower lane. A 3-bit status code gives the cycle type while a cycle is active. The block returns read data and pulses `done_o` once, after the last cycle of the transfer has finished.

Top module: `mux_bus_seq`

## Requirements
- R1: An accepted request (`req_valid_i` high while `busy_o` is low) runs bus cycles of T1, T2, T3, any wait states, and T4, one clock each. With no wait states a single-cycle transfer asserts `done_o` in its 4th clock after acceptance.
- R2: `ale_o` is high only in T1. In T1, `ad_o` carries the full address of that bus cycle and both `rd_no` and `wr_no` are high.
- R3: For a write, `wr_no` is low from T2 through T3 and all wait states, and high in T4. From T2 onward `ad_o[15:0]` carries the lane-aligned write data: the full word for an aligned word, and otherwise the byte repeated on both halves.
- R4: For a read, `rd_no` is low from T2 through T3 and all wait states, and high in T4. Read data is taken from `bus_rdata_i` on the edge that leaves the last T3 or wait state.
- R5: `ready_i` is sampled on the edge that ends T3 and on the edge that ends each wait state. Each low sample adds exactly one wait state, and the strobes stay asserted through it.
- R6: In T1 the pair (`bhe_no`, `ad_o[0]`) gives the lanes: 00 is a word on bits 15:0, 01 is the upper byte (odd address), and 10 is the lower byte (even address). `bhe_no` is high while idle.
- R7: `status_o` is 001 for an I/O read, 010 for an I/O write, 101 for a memory read and 110 for a memory write, from T1 through the last wait state. It is 111 (passive) in T4 and while idle.
- R8: A word at an odd address N runs as two bus cycles. The first is at N on the upper lane and carries the low byte. The second is at N+1 on the lower lane and carries the high byte. `done_o` pulses only in the T4 of the second cycle, and `rdata_o` holds the two bytes reassembled.
- R9: A byte read returns the selected lane byte zero-extended on `rdata_o`. An aligned word read returns `bus_rdata_i` unchanged.
- R10: A request raised while a transfer is in progress is ignored. No extra bus cycle follows, and `busy_o` falls once the transfer ends.
- R11: After reset the block is idle: `ale_o` low, `rd_no`, `wr_no` and `bhe_no` high, `status_o` 111, and `done_o` and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request, taken while idle |
| req_addr_i | input | ADDR_W | Byte address |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_wdata_i | input | 16 | Write data, low byte in bits 7:0 |
| ready_i | input | 1 | Slave ready; low adds a wait state |
| bus_rdata_i | input | 16 | Data the slave returns on the shared lines |
| ad_o | output | ADDR_W | Shared lines: address in T1, write data afterwards |
| ale_o | output | 1 | Address latch strobe |
| bhe_no | output | 1 | High-byte enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| status_o | output | 3 | Cycle type code |
| rdata_o | output | 16 | Read result |
| done_o | output | 1 | One-cycle pulse at the end of the transfer |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The bench raises the request at a falling edge and counts clocks from there. The clock after acceptance is T1, then T2 and T3, then one clock for each wait state the bench asked for, then T4, in which `done_o` is due. A split transfer takes twice that span. The slave model drives `ready_i` at the falling edge ahead of the rising edge that samples it. That edge ends T3 or a wait state, so each low value adds exactly one clock. All outputs are checked at falling edges against the phase the bench expects from this count: the address and lanes in T1, the write data in T2, the strobes and status through the waits, and the passive status and read data in T4.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } t_state_e;

  localparam logic [2:0] ST_IO_RD   = 3'b001;
  localparam logic [2:0] ST_IO_WR   = 3'b010;
  localparam logic [2:0] ST_MEM_RD  = 3'b101;
  localparam logic [2:0] ST_MEM_WR  = 3'b110;
  localparam logic [2:0] ST_PASSIVE = 3'b111;
endpackage

// File: rtl/mbs_tstate_fsm.sv
module mbs_tstate_fsm
  import mbs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     split_i,
  input  logic     ready_i,
  output t_state_e state_o,
  output logic     second_o,
  output logic     last_o
);
  t_state_e state_q, state_d;
  logic     second_q;
  logic     more;

  assign more = split_i && !second_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: if (start_i) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      TS_T3,
      TS_TW:   state_d = ready_i ? TS_T4 : TS_TW;
      TS_T4:   state_d = more ? TS_T1 : TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TS_IDLE;
      second_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == TS_T4) second_q <= more;
    end
  end

  assign state_o  = state_q;
  assign second_o = second_q;
  assign last_o   = (state_q == TS_T4) && !more;

  assert_t1_to_t2_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == TS_T1 |=> state_q == TS_T2);
  assert_wait_on_low_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_T3 || state_q == TS_TW) && !ready_i |=> state_q == TS_TW);
  assert_t4_on_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_T3 || state_q == TS_TW) && ready_i |=> state_q == TS_T4);
  assert_split_second_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == TS_T4 && split_i && !second_q |=> state_q == TS_T1 && second_q);
endmodule

// File: rtl/mbs_lane_plan.sv
module mbs_lane_plan
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic              second_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] cyc_addr_o,
  output logic              bhe_n_o,
  output logic              split_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  logic              aligned_word;
  logic [BYTE_W-1:0] wbyte;

  assign split_o      = word_i && addr_i[0];
  assign aligned_word = word_i && !addr_i[0];
  assign cyc_addr_o   = addr_i + ADDR_W'(second_i);
  // second half of a split carries the high byte
  assign wbyte        = second_i ? wdata_i[DATA_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];

  always_comb begin
    if (aligned_word) begin
      bhe_n_o     = 1'b0;
      bus_wdata_o = wdata_i;
    end else begin
      bhe_n_o     = !cyc_addr_o[0];
      bus_wdata_o = {wbyte, wbyte};
    end
  end

  assign rd_byte_o = cyc_addr_o[0] ? bus_rdata_i[DATA_W-1:BYTE_W] : bus_rdata_i[BYTE_W-1:0];
endmodule

// File: rtl/mbs_status_enc.sv
module mbs_status_enc
  import mbs_pkg::*;
(
  input  t_state_e   state_i,
  input  logic       io_i,
  input  logic       write_i,
  output logic [2:0] status_o
);
  logic active;
  assign active = (state_i == TS_T1) || (state_i == TS_T2) ||
                  (state_i == TS_T3) || (state_i == TS_TW);

  always_comb begin
    if (!active)      status_o = ST_PASSIVE;
    else if (io_i)    status_o = write_i ? ST_IO_WR : ST_IO_RD;
    else              status_o = write_i ? ST_MEM_WR : ST_MEM_RD;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_io_i,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [15:0]       req_wdata_i,
  input  logic              ready_i,
  input  logic [15:0]       bus_rdata_i,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ale_o,
  output logic              bhe_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [2:0]        status_o,
  output logic [15:0]       rdata_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int PAD_W = ADDR_W - DATA_W;

  t_state_e          state;
  logic              second, last, split, accept, strobe_ph, capture, bhe_n;
  logic [ADDR_W-1:0] addr_q, cyc_addr;
  logic              io_q, wr_q, word_q;
  logic [DATA_W-1:0] wdata_q, bus_wdata, rdata_q;
  logic [BYTE_W-1:0] rd_byte;

  assign accept = req_valid_i && (state == TS_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      io_q    <= req_io_i;
      wr_q    <= req_write_i;
      word_q  <= req_word_i;
      wdata_q <= req_wdata_i;
    end
  end

  mbs_tstate_fsm i_fsm (
    .clk_i, .rst_ni, .start_i(accept), .split_i(split), .ready_i,
    .state_o(state), .second_o(second), .last_o(last)
  );

  mbs_lane_plan #(.ADDR_W(ADDR_W)) i_lanes (
    .addr_i(addr_q), .word_i(word_q), .second_i(second), .wdata_i(wdata_q),
    .bus_rdata_i, .cyc_addr_o(cyc_addr), .bhe_n_o(bhe_n), .split_o(split),
    .bus_wdata_o(bus_wdata), .rd_byte_o(rd_byte)
  );

  mbs_status_enc i_status (
    .state_i(state), .io_i(io_q), .write_i(wr_q), .status_o
  );

  assign strobe_ph = (state == TS_T2) || (state == TS_T3) || (state == TS_TW);
  assign capture   = ((state == TS_T3) || (state == TS_TW)) && ready_i && !wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (capture) begin
      if (!word_q)           rdata_q <= {8'h00, rd_byte};
      else if (!split)       rdata_q <= bus_rdata_i;
      else if (!second)      rdata_q[7:0]  <= rd_byte;
      else                   rdata_q[15:8] <= rd_byte;
    end
  end

  always_comb begin
    if (state == TS_T1)             ad_o = cyc_addr;
    else if (strobe_ph && wr_q)     ad_o = {{PAD_W{1'b0}}, bus_wdata};
    else                            ad_o = '0;
  end

  assign ale_o   = (state == TS_T1);
  assign bhe_no  = (state == TS_IDLE) ? 1'b1 : bhe_n;
  assign rd_no   = !(strobe_ph && !wr_q);
  assign wr_no   = !(strobe_ph && wr_q);
  assign rdata_o = rdata_q;
  assign done_o  = last;
  assign busy_o  = (state != TS_IDLE);

  assert_strobes_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  assert_ale_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> rd_no && wr_no);
  assert_done_passive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> status_o == ST_PASSIVE && rd_no && wr_no);
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_bhe_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> bhe_no && status_o == ST_PASSIVE);
  assert_busy_ignores_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic        req_io_i = 1'b0, req_write_i = 1'b0, req_word_i = 1'b0;
  logic [15:0] req_wdata_i = '0;
  logic        ready_i = 1'b1;
  logic [15:0] bus_rdata_i = '0;
  logic [19:0] ad_o;
  logic        ale_o, bhe_no, rd_no, wr_no, done_o, busy_o;
  logic [2:0]  status_o;
  logic [15:0] rdata_o;
  int checks = 0, failures = 0, ticks = 0;

  always #4 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_addr_i, .req_io_i, .req_write_i,
    .req_word_i, .req_wdata_i, .ready_i, .bus_rdata_i, .ad_o, .ale_o, .bhe_no,
    .rd_no, .wr_no, .status_o, .rdata_o, .done_o, .busy_o
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [19:0] addr, input logic io, input logic wr,
                          input logic word, input logic [15:0] wd, input logic [15:0] rbus,
                          input int nwait, input logic poke, input int exp_n,
                          input logic [15:0] exp_d0, input logic [15:0] exp_d1,
                          input logic [15:0] exp_rd, input logic [2:0] exp_st);
    int cyc = 0, phase = 0, nale = 0, wcnt = 0;
    logic seen_done = 1'b0;
    logic [19:0] ea;
    logic exp_bhe, strobe_exp;
    @(negedge clk);
    req_addr_i = addr; req_io_i = io; req_write_i = wr; req_word_i = word;
    req_wdata_i = wd; bus_rdata_i = rbus; ready_i = 1'b1; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    while (!seen_done && cyc < 100) begin
      cyc++;
      if (ale_o) begin
        ea = (nale == 0) ? addr : addr + 20'd1;
        exp_bhe = (word && !addr[0]) ? 1'b0 : !ea[0];
        chk(ad_o == ea, "R2", "T1 address", 32'(ad_o), 32'(ea));
        chk({bhe_no, ad_o[0]} == {exp_bhe, ea[0]}, "R6", "lane pair",
            32'({bhe_no, ad_o[0]}), 32'({exp_bhe, ea[0]}));
        phase = 0; wcnt = 0; nale++;
      end else phase++;
      strobe_exp = (phase >= 1) && (phase <= 2 + nwait);
      if (wr) chk(wr_no == !strobe_exp && rd_no, "R3", "write strobes",
                  32'({rd_no, wr_no}), 32'({1'b1, !strobe_exp}));
      else    chk(rd_no == !strobe_exp && wr_no, "R4", "read strobes",
                  32'({rd_no, wr_no}), 32'({!strobe_exp, 1'b1}));
      chk(status_o == ((phase <= 2 + nwait) ? exp_st : 3'b111), "R7", "status",
          32'(status_o), 32'((phase <= 2 + nwait) ? exp_st : 3'b111));
      if (phase == 1 && wr)
        chk(ad_o[15:0] == ((nale == 1) ? exp_d0 : exp_d1), "R3", "write data",
            32'(ad_o[15:0]), 32'((nale == 1) ? exp_d0 : exp_d1));
      if (done_o) begin
        seen_done = 1'b1;
        chk(nale == exp_n, "R8", "bus cycle count", 32'(nale), 32'(exp_n));
        chk(cyc == exp_n * (4 + nwait), "R1", "cycles to done (R5 waits)",
            32'(cyc), 32'(exp_n * (4 + nwait)));
        if (!wr) chk(rdata_o == exp_rd, "R9", "read data", 32'(rdata_o), 32'(exp_rd));
      end
      if (poke && cyc == 2) begin req_valid_i = 1'b1; req_addr_i = 20'h55554; end
      if (poke && cyc == 3) req_valid_i = 1'b0;
      if (phase >= 2 && wcnt < nwait) begin ready_i = 1'b0; wcnt++; end
      else ready_i = 1'b1;
      if (!seen_done) @(negedge clk);
    end
    chk(seen_done, "R1", "done seen", 32'(seen_done), 32'd1);
    repeat (2) begin
      @(negedge clk);
      chk(!busy_o && !ale_o && !done_o && bhe_no, "R10", "idle after transfer",
          32'({busy_o, ale_o, done_o, bhe_no}), 32'b0001);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!ale_o && rd_no && wr_no && bhe_no && !done_o && !busy_o, "R11", "reset outputs",
        32'({ale_o, rd_no, wr_no, bhe_no, done_o, busy_o}), 32'b011100);
    chk(status_o == 3'b111, "R11", "reset status", 32'(status_o), 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    // aligned memory word read, no waits
    run_xfer(20'h12344, 0, 0, 1, 16'h0000, 16'hA1B2, 0, 0, 1, 16'h0, 16'h0, 16'hA1B2, 3'b101);
    // aligned memory word write, two waits
    run_xfer(20'h00100, 0, 1, 1, 16'h9876, 16'h0000, 2, 0, 1, 16'h9876, 16'h0, 16'h0, 3'b110);
    // odd I/O byte write
    run_xfer(20'h00099, 1, 1, 0, 16'h1255, 16'h0000, 0, 0, 1, 16'h5555, 16'h0, 16'h0, 3'b010);
    // even I/O byte read, one wait
    run_xfer(20'h00040, 1, 0, 0, 16'h0000, 16'hA1B2, 1, 0, 1, 16'h0, 16'h0, 16'h00B2, 3'b001);
    // odd I/O byte read
    run_xfer(20'h00041, 1, 0, 0, 16'h0000, 16'hA1B2, 0, 0, 1, 16'h0, 16'h0, 16'h00A1, 3'b001);
    // odd memory word write, split, one wait per cycle
    run_xfer(20'h00201, 0, 1, 1, 16'h9876, 16'h0000, 1, 0, 2, 16'h7676, 16'h9898, 16'h0, 3'b110);
    // odd memory word read, split across 64K boundary
    run_xfer(20'h0FFFF, 0, 0, 1, 16'h0000, 16'hA1B2, 0, 0, 2, 16'h0, 16'h0, 16'hB2A1, 3'b101);
    // odd I/O word write (port N, N+1), split
    run_xfer(20'h00041, 1, 1, 1, 16'h9876, 16'h0000, 0, 0, 2, 16'h7676, 16'h9898, 16'h0, 3'b010);
    // request raised mid-transfer is ignored
    run_xfer(20'h00300, 0, 0, 1, 16'h0000, 16'h1234, 1, 1, 1, 16'h0, 16'h0, 16'h1234, 3'b101);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", ticks, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule